// File: doc/BRIEF.md
# Dual Add-Compare-Select Butterfly for Viterbi Decoding

This unit carries out the add-compare-select step of a Viterbi decoder, one full butterfly per clock. Each valid cycle brings two 16-bit path metrics packed into one 32-bit word and two 16-bit branch metrics packed into another. Four sums are formed side by side: two compete for the first new metric and two for the second. The packed result and one decision bit per compare are registered together.

Each decision bit also enters its own 16-bit survivor shift register. A pulse marks every sixteenth decision so that a traceback engine outside this unit can collect full words. A mode input turns the unit into a single narrow ACS. The low 16-bit adder is split into two independent 8-bit lanes, and the smaller of the two byte sums is selected.

Top module: `vit_acs_pair`

## Requirements
- R1: In dual mode (`split_mode`=0), `pm_out[15:0]` is the smaller of (pm_word[15:0]+bm_word[15:0]) and (pm_word[31:16]+bm_word[31:16]), and `dec_out[0]` is 1 exactly when the second sum is strictly smaller.
- R2: In dual mode, `pm_out[31:16]` is the smaller of (pm_word[15:0]+bm_word[31:16]) and (pm_word[31:16]+bm_word[15:0]), and `dec_out[1]` is 1 exactly when the second sum is strictly smaller.
- R3: When the two candidates of a compare are equal, the candidate built on pm_word[15:0] wins and its decision bit is 0.
- R4: Results, `dec_out` and `out_valid` appear in the cycle after `in_valid` is sampled high. In a cycle after `in_valid` was low, `out_valid` is 0 and `pm_out`, `dec_out` and both survivors hold their values.
- R5: On each valid input, both survivor registers shift left by one bit. `dec_out[0]` enters bit 0 of `surv0`, and `dec_out[1]` enters bit 0 of `surv1`.
- R6: `surv_full` is high for exactly the one output cycle that carries the 16th, 32nd, ... decision counted since reset.
- R7: In split mode (`split_mode`=1), the byte lanes add without any carry between them, each modulo 256. `pm_out[23:16]` = pm_word[7:0]+bm_word[7:0] and `pm_out[31:24]` = pm_word[15:8]+bm_word[15:8].
- R8: In split mode, `pm_out[7:0]` is the smaller lane sum, with a tie going to the low lane. `dec_out[0]` is 1 exactly when the high lane is strictly smaller. `dec_out[1]` and `pm_out[15:8]` are 0, so `surv1` shifts in 0.
- R9: After reset, all outputs and both survivor registers are 0.
- R10: Dual-mode sums are unsigned and wrap modulo 65536 before the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| split_mode | input | 1 | 0: dual 16-bit butterfly, 1: single ACS on two 8-bit lanes |
| pm_word | input | 32 | Packed path metrics {upper, lower} |
| bm_word | input | 32 | Packed branch metrics {upper, lower} |
| out_valid | output | 1 | Registered result valid |
| pm_out | output | 32 | Packed new metrics (layout per mode) |
| dec_out | output | 2 | Decision bits of the two compares |
| surv0 | output | 16 | Survivor shift register fed by dec_out[0] |
| surv1 | output | 16 | Survivor shift register fed by dec_out[1] |
| surv_full | output | 1 | Pulse on every 16th decision |

## Verification
The bench builds the unit with its default parameters: 16-bit metrics, 8-bit lanes and 16-deep survivors. With these values, the byte-lane carry boundary can be reached with single-byte operands. A wrap of a 16-bit sum needs only one large metric. The survivor wrap pulse occurs after sixteen operations, which keeps the run short. The directed scenarios cover ties on both compares, sums that wrap, and a low-lane carry that must not reach the high lane. They also include idle gaps and a long run across the sixteenth decision.

// File: rtl/acs_pkg.sv
package acs_pkg;
   typedef enum logic {
      ACS_DUAL  = 1'b0,
      ACS_SPLIT = 1'b1
   } acs_mode_e;

   localparam int unsigned ACS_DEF_MW    = 16;
   localparam int unsigned ACS_DEF_LW    = 8;
   localparam int unsigned ACS_DEF_DEPTH = 16;
endpackage

// File: rtl/acs_split_adder.sv
module acs_split_adder #(
   parameter int unsigned W          = 16,
   parameter int unsigned LW         = 8,
   parameter bit          SPLITTABLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         split,
   output logic [W-1:0] sum
);
   localparam int unsigned NL = W / LW;

   generate
      if (W % LW != 0) begin : g_bad_lane
         $error("acs_split_adder: W must be a multiple of LW");
      end
   endgenerate

   logic cut;
   generate
      if (SPLITTABLE) begin : g_cut
         assign cut = split;
      end else begin : g_nocut
         logic unused_split;
         assign unused_split = split;
         assign cut = 1'b0;
      end
   endgenerate

   logic [NL-1:0] cin;
   assign cin[0] = 1'b0;

   genvar i;
   generate
      for (i = 0; i < NL; i++) begin : g_lane
         if (i == NL - 1) begin : g_top
            assign sum[i*LW +: LW] = a[i*LW +: LW] + b[i*LW +: LW] + {{(LW-1){1'b0}}, cin[i]};
         end else begin : g_mid
            logic co;
            assign {co, sum[i*LW +: LW]} = {1'b0, a[i*LW +: LW]} + {1'b0, b[i*LW +: LW]}
                                           + {{LW{1'b0}}, cin[i]};
            assign cin[i+1] = co & ~cut;
         end
      end
   endgenerate
endmodule

// File: rtl/acs_select.sv
module acs_select #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] keep_v,
   input  logic [W-1:0] alt_v,
   output logic [W-1:0] win_v,
   output logic         pick_alt
);
   always_comb begin
      pick_alt = (alt_v < keep_v);
      win_v    = pick_alt ? alt_v : keep_v;
   end
endmodule

// File: rtl/acs_survivor.sv
module acs_survivor #(
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [DEPTH-1:0] bits
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("acs_survivor: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        bits <= '0;
      else if (shift_en) bits <= {bits[DEPTH-2:0], bit_in};
   end
endmodule

// File: rtl/acs_wrap_counter.sv
module acs_wrap_counter #(
   parameter int unsigned DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic wrap
);
   localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         wrap <= 1'b0;
      end else begin
         wrap <= step && (cnt == LAST);
         if (step) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vit_acs_pair.sv
module vit_acs_pair #(
   parameter int unsigned MW    = acs_pkg::ACS_DEF_MW,
   parameter int unsigned LW    = acs_pkg::ACS_DEF_LW,
   parameter int unsigned DEPTH = acs_pkg::ACS_DEF_DEPTH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            split_mode,
   input  logic [2*MW-1:0] pm_word,
   input  logic [2*MW-1:0] bm_word,
   output logic            out_valid,
   output logic [2*MW-1:0] pm_out,
   output logic [1:0]      dec_out,
   output logic [DEPTH-1:0] surv0,
   output logic [DEPTH-1:0] surv1,
   output logic            surv_full
);
   import acs_pkg::*;

   localparam int unsigned PW = 2 * MW;

   generate
      if (MW != 2 * LW) begin : g_bad_width
         $error("vit_acs_pair: MW must equal twice LW");
      end
   endgenerate

   acs_mode_e mode;
   assign mode = acs_mode_e'(split_mode);

   logic [MW-1:0] pm_lo, pm_hi, bm_lo, bm_hi;
   assign pm_lo = pm_word[MW-1:0];
   assign pm_hi = pm_word[PW-1:MW];
   assign bm_lo = bm_word[MW-1:0];
   assign bm_hi = bm_word[PW-1:MW];

   logic [MW-1:0] s_straight_lo, s_straight_hi, s_cross_lo, s_cross_hi;

   acs_split_adder #(.W(MW), .LW(LW), .SPLITTABLE(1'b1)) u_add_a (
      .a(pm_lo), .b(bm_lo), .split(mode == ACS_SPLIT), .sum(s_straight_lo));
   acs_split_adder #(.W(MW), .LW(LW), .SPLITTABLE(1'b0)) u_add_b (
      .a(pm_hi), .b(bm_hi), .split(1'b0), .sum(s_straight_hi));
   acs_split_adder #(.W(MW), .LW(LW), .SPLITTABLE(1'b0)) u_add_c (
      .a(pm_lo), .b(bm_hi), .split(1'b0), .sum(s_cross_lo));
   acs_split_adder #(.W(MW), .LW(LW), .SPLITTABLE(1'b0)) u_add_d (
      .a(pm_hi), .b(bm_lo), .split(1'b0), .sum(s_cross_hi));

   logic [MW-1:0] win_a, win_b;
   logic [LW-1:0] win_s;
   logic          pick_a, pick_b, pick_s;

   acs_select #(.W(MW)) u_sel_a (
      .keep_v(s_straight_lo), .alt_v(s_straight_hi), .win_v(win_a), .pick_alt(pick_a));
   acs_select #(.W(MW)) u_sel_b (
      .keep_v(s_cross_lo), .alt_v(s_cross_hi), .win_v(win_b), .pick_alt(pick_b));
   acs_select #(.W(LW)) u_sel_s (
      .keep_v(s_straight_lo[LW-1:0]), .alt_v(s_straight_lo[MW-1:LW]),
      .win_v(win_s), .pick_alt(pick_s));

   logic [PW-1:0] pm_next;
   logic [1:0]    dec_next;

   always_comb begin
      if (mode == ACS_SPLIT) begin
         pm_next  = {s_straight_lo, {(MW-LW){1'b0}}, win_s};
         dec_next = {1'b0, pick_s};
      end else begin
         pm_next  = {win_b, win_a};
         dec_next = {pick_b, pick_a};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pm_out    <= '0;
         dec_out   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pm_out  <= pm_next;
            dec_out <= dec_next;
         end
      end
   end

   acs_survivor #(.DEPTH(DEPTH)) u_surv0 (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .bit_in(dec_next[0]), .bits(surv0));
   acs_survivor #(.DEPTH(DEPTH)) u_surv1 (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .bit_in(dec_next[1]), .bits(surv1));

   acs_wrap_counter #(.DEPTH(DEPTH)) u_wrap (
      .clk(clk), .rst_n(rst_n), .step(in_valid), .wrap(surv_full));

   // Checks next to the datapath they guard
   assert_lo_is_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !split_mode) |=>
         (pm_out[MW-1:0] <= $past(pm_word[MW-1:0] + bm_word[MW-1:0])) &&
         (pm_out[MW-1:0] <= $past(pm_word[PW-1:MW] + bm_word[PW-1:MW])));

   assert_hi_is_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !split_mode) |=>
         (pm_out[PW-1:MW] <= $past(pm_word[MW-1:0] + bm_word[PW-1:MW])) &&
         (pm_out[PW-1:MW] <= $past(pm_word[PW-1:MW] + bm_word[MW-1:0])));

   assert_tie_keeps_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !split_mode &&
       (MW'(pm_word[MW-1:0] + bm_word[MW-1:0]) == MW'(pm_word[PW-1:MW] + bm_word[PW-1:MW])))
      |=> !dec_out[0]);

   assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(pm_out) && $stable(dec_out) && $stable(surv0));

   assert_survivor_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (surv0[DEPTH-1:1] == $past(surv0[DEPTH-2:0])) && (surv0[0] == dec_out[0]) &&
                   (surv1[0] == dec_out[1]));

   assert_full_on_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
      surv_full |-> out_valid);

   assert_split_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && split_mode) |=> !dec_out[1] && (pm_out[MW-1:LW] == '0));
endmodule

// File: tb/sim_vit_acs_pair.sv
module sim_vit_acs_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        split_mode = 1'b0;
   logic [31:0] pm_word = '0;
   logic [31:0] bm_word = '0;
   logic        out_valid;
   logic [31:0] pm_out;
   logic [1:0]  dec_out;
   logic [15:0] surv0, surv1;
   logic        surv_full;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] m_s0 = '0, m_s1 = '0;
   int m_count = 0;
   logic [31:0] last_pm = '0;

   always #4 clk = ~clk;

   vit_acs_pair u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .split_mode(split_mode),
      .pm_word(pm_word), .bm_word(bm_word), .out_valid(out_valid), .pm_out(pm_out),
      .dec_out(dec_out), .surv0(surv0), .surv1(surv1), .surv_full(surv_full));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] pm, input logic [31:0] bm, input bit sp,
                                 output logic [31:0] epm, output logic [1:0] edec);
      logic [15:0] a, b, c, d;
      logic [7:0]  lo, hi;
      a = pm[15:0] + bm[15:0];
      b = pm[31:16] + bm[31:16];
      c = pm[15:0] + bm[31:16];
      d = pm[31:16] + bm[15:0];
      lo = pm[7:0] + bm[7:0];
      hi = pm[15:8] + bm[15:8];
      if (sp) begin
         epm  = {hi, lo, 8'h00, (hi < lo) ? hi : lo};
         edec = {1'b0, hi < lo};
      end else begin
         epm  = {(d < c) ? d : c, (b < a) ? b : a};
         edec = {d < c, b < a};
      end
   endfunction

   task automatic do_op(input logic [31:0] pm, input logic [31:0] bm, input bit sp,
                        input string req);
      logic [31:0] epm;
      logic [1:0]  edec;
      model(pm, bm, sp, epm, edec);
      m_s0 = {m_s0[14:0], edec[0]};
      m_s1 = {m_s1[14:0], edec[1]};
      m_count++;
      @(negedge clk);
      in_valid = 1'b1; split_mode = sp; pm_word = pm; bm_word = bm;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " pm_out"}, pm_out, epm);
      chk({req, " dec_out"}, {30'd0, dec_out}, {30'd0, edec});
      chk("R4 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R5 surv0", {16'd0, surv0}, {16'd0, m_s0});
      chk("R5 surv1", {16'd0, surv1}, {16'd0, m_s1});
      chk("R6 surv_full", {31'd0, surv_full}, {31'd0, (m_count % 16) == 0});
      last_pm = epm;
   endtask

   task automatic t_reset;
      chk("R9 pm_out", pm_out, 32'd0);
      chk("R9 dec/valid/full", {28'd0, dec_out, out_valid, surv_full}, 32'd0);
      chk("R9 survivors", {surv1, surv0}, 32'd0);
   endtask

   task automatic t_dual;
      do_op({16'd100, 16'd50}, {16'd10, 16'd20}, 1'b0, "R1 R2 basic");
      do_op({16'd5, 16'd300}, {16'd7, 16'd1}, 1'b0, "R1 R2 upper wins");
      do_op({16'h1234, 16'h0010}, {16'h0400, 16'h0020}, 1'b0, "R1 R2 mixed");
      do_op({16'd0, 16'd0}, {16'd0, 16'd0}, 1'b0, "R1 R2 zeros");
   endtask

   task automatic t_ties;
      // straight pair 30+10 vs 20+20, cross pair 30+20 vs 20+10 (cross not tied)
      do_op({16'd20, 16'd30}, {16'd20, 16'd10}, 1'b0, "R3 tie straight");
      // cross pair 10+40 vs 30+20 tie; straight pair 10+20 vs 30+40
      do_op({16'd30, 16'd10}, {16'd40, 16'd20}, 1'b0, "R3 tie cross");
   endtask

   task automatic t_wrap;
      do_op({16'd100, 16'hFFF0}, {16'd5, 16'h0020}, 1'b0, "R10 wrap straight");
      do_op({16'hFFFF, 16'd3}, {16'd9, 16'd2}, 1'b0, "R10 wrap cross");
   endtask

   task automatic t_split;
      do_op({16'hAAAA, 16'h30F0}, {16'h5555, 16'h0420}, 1'b1, "R7 R8 low carry blocked");
      do_op({16'h0, 16'h0510}, {16'h0, 16'h0202}, 1'b1, "R7 R8 high smaller");
      do_op({16'h0, 16'h0808}, {16'h0, 16'h0101}, 1'b1, "R8 lane tie");
      do_op({16'h0, 16'hFFFF}, {16'h0, 16'h0101}, 1'b1, "R7 both lanes wrap");
   endtask

   task automatic t_hold;
      repeat (3) @(negedge clk);
      chk("R4 idle out_valid", {31'd0, out_valid}, 32'd0);
      chk("R4 idle pm_out held", pm_out, last_pm);
      chk("R4 idle survivors held", {surv1, surv0}, {m_s1, m_s0});
      chk("R6 idle full low", {31'd0, surv_full}, 32'd0);
   endtask

   task automatic t_full;
      for (int k = 0; k < 22; k++) begin
         do_op({16'(k * 3), 16'(k * 7)}, {16'(k), 16'(40 - k)}, 1'b0, "R6 R5 run");
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dual();
      t_ties();
      t_wrap();
      t_hold();
      t_split();
      t_hold();
      t_full();
      t_hold();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule